// File: doc/BRIEF.md
# Oscillator Band-Select Timing Sequencer

This block times the automatic selection of an oscillator band in a frequency synthesizer. It takes the phase-detector-rate tick from the reference divider and divides it again by 1, 2, 4 or 8 to form a slow band-select clock. It runs one selection window at power-up and another each time the divider-setting latch is written. For the length of the window it holds a control high that cuts the tuning node off from the loop filter and ties it to an internal reference. After five band-select clocks it drops that control, so normal loop action resumes, and it raises a one-cycle completion pulse.

The actual choice of band is reduced to a placeholder. A 3-bit band result, one of eight bands, steps forward each time a window completes. The analog switching sits outside the block. The block is driven from one system clock. The detector tick and the latch-write trigger are single-cycle strobes in that clock domain.

Top module: `band_select_sequencer`

## Requirements
- R1: While reset is low, and on the first clock after reset, `tune_isolate` is 1, `sel_done` is 0 and `band_code` is 0. A selection window begins when reset is released, with the prescaler starting from zero.
- R2: `div_sel` sets the prescale: 00 gives one band-select clock per detector tick, 01 one per 2 ticks, 10 one per 4 ticks and 11 one per 8 ticks. The band-select clock falls on the last tick of each group, counted from the most recent reset or trigger.
- R3: A window ends at the clock edge that samples its fifth band-select clock. With a detector tick on every cycle, `tune_isolate` therefore drops 5·2^div_sel cycles after the triggering edge.
- R4: `tune_isolate` stays at 1 from the start of a window until the window ends, and it is 0 outside a window.
- R5: `sel_done` is high for exactly one cycle. That cycle is the first one in which `tune_isolate` is back at 0.
- R6: A pulse on `nlatch_wr` restarts the window and the prescaler from zero, including during a running window. It takes priority over a detector tick in the same cycle.
- R7: `band_code` increases by one, modulo 8, in the cycle in which `sel_done` is high, and it holds its value at all other times. A window cut short by a restart does not advance it.
- R8: Detector ticks that arrive outside a window leave `tune_isolate`, `sel_done` and `band_code` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfd_tick | input | 1 | One-cycle strobe at the phase-detector rate |
| div_sel | input | 2 | Band-select clock prescale (00:/1, 01:/2, 10:/4, 11:/8) |
| nlatch_wr | input | 1 | One-cycle strobe when the divider-setting latch is written |
| tune_isolate | output | 1 | High while the tuning node is isolated for band selection |
| sel_done | output | 1 | One-cycle pulse when a selection window completes |
| band_code | output | 3 | Placeholder selected band |

## Verification
All three outputs are registered. Each one changes at the clock edge that samples its cause: the trigger, or the fifth band-select clock, which is also a detector tick. No output lags that edge by an extra cycle. The bench drives inputs at the falling edge and steps its model at the rising edge using the values it drove. It compares every output a quarter period later, so each result is checked in the cycle in which it is due. Directed runs count the cycles from a trigger to `sel_done` and expect 5·2^div_sel with a tick every cycle. They also check that a restart in mid-window yields a full fresh window.

// File: rtl/bsel_pkg.sv
// Shared constants and types for the band-select timing sequencer.
// Assumes: a single clock domain; all users import this package.
package bsel_pkg;
    localparam int SEL_W      = 2;   // width of the prescale select field
    localparam int BAND_W     = 3;   // eight bands
    localparam int WIN_CLOCKS = 5;   // band-select clocks per window

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SELECT = 1'b1
    } phase_e;
endpackage

// File: rtl/bsel_prescaler.sv
// Divides the detector-rate tick by 2^div_sel to make band-select clock ticks.
// Assumes: pfd_tick is a one-cycle strobe; restart and reset clear the count,
// so each group of ticks is counted from the last restart.
module bsel_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pfd_tick,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             bs_tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] tick_cnt;
    logic [CNT_W-1:0] grp_mask;

    // Low-order mask: the first div_sel bits set.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            grp_mask[i] = (i < int'(div_sel));
        end
    end

    // Band-select tick on the last detector tick of each group.
    assign bs_tick = pfd_tick && !restart && ((tick_cnt & grp_mask) == grp_mask);

    // Count detector ticks, cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tick_cnt <= '0;
        end else if (pfd_tick) begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    AST_TICK_NEEDS_PFD: assert property (@(posedge clk) disable iff (!rst_n)
        bs_tick |-> pfd_tick); // R2
    AST_DIV1_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == '0 && pfd_tick && !restart) |-> bs_tick); // R2
endmodule

// File: rtl/bsel_window.sv
// Holds the isolation window open for a fixed number of band-select clocks,
// then drops it and raises a one-cycle completion pulse.
// Assumes: reset starts the power-up window; restart has priority over ticks.
module bsel_window
    import bsel_pkg::*;
#(
    parameter int WIN_CLOCKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic bs_tick,
    output logic isolate,
    output logic finish,
    output logic done
);
    localparam int WC_W = (WIN_CLOCKS > 1) ? $clog2(WIN_CLOCKS) : 1;
    localparam logic [WC_W-1:0] LAST = WC_W'(WIN_CLOCKS - 1);

    phase_e          phase;
    logic [WC_W-1:0] win_cnt;

    // Last band-select clock of a window that is not being restarted.
    assign finish  = (phase == PH_SELECT) && bs_tick && !restart && (win_cnt == LAST);
    assign isolate = (phase == PH_SELECT);

    // Window phase, clock count and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase   <= PH_SELECT;
            win_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (finish) begin
                phase   <= PH_IDLE;
                win_cnt <= '0;
                done    <= 1'b1;
            end else if (phase == PH_SELECT && bs_tick) begin
                win_cnt <= win_cnt + 1'b1;
            end
        end
    end

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (isolate && win_cnt == '0)); // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= LAST); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!isolate && $past(isolate))); // R5
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!isolate && !restart) |=> !isolate); // R8
endmodule

// File: rtl/bsel_band_track.sv
// Placeholder band result: advances by one per completed window, wrapping.
// Assumes: finish is high for one cycle at the end of each completed window.
module bsel_band_track #(
    parameter int BAND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              finish,
    output logic [BAND_W-1:0] band_code
);
    // Step the band result when a window completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_code <= '0;
        end else if (finish) begin
            band_code <= band_code + 1'b1;
        end
    end
endmodule

// File: rtl/band_select_sequencer.sv
// Top of the band-select timing sequencer: prescaler, window, band tracker.
// Assumes: pfd_tick and nlatch_wr are one-cycle strobes in the clk domain.
module band_select_sequencer
    import bsel_pkg::*;
#(
    parameter int SEL_W_P      = SEL_W,
    parameter int BAND_W_P     = BAND_W,
    parameter int WIN_CLOCKS_P = WIN_CLOCKS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pfd_tick,
    input  logic [SEL_W_P-1:0]  div_sel,
    input  logic                nlatch_wr,
    output logic                tune_isolate,
    output logic                sel_done,
    output logic [BAND_W_P-1:0] band_code
);
    logic bs_tick;
    logic win_finish;

    bsel_prescaler #(.SEL_W(SEL_W_P)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pfd_tick (pfd_tick),
        .restart  (nlatch_wr),
        .div_sel  (div_sel),
        .bs_tick  (bs_tick)
    );

    bsel_window #(.WIN_CLOCKS(WIN_CLOCKS_P)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (nlatch_wr),
        .bs_tick (bs_tick),
        .isolate (tune_isolate),
        .finish  (win_finish),
        .done    (sel_done)
    );

    bsel_band_track #(.BAND_W(BAND_W_P)) u_band (
        .clk       (clk),
        .rst_n     (rst_n),
        .finish    (win_finish),
        .band_code (band_code)
    );

    AST_BAND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sel_done |-> (band_code == $past(band_code) + BAND_W_P'(1))); // R7
    AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_done |-> $stable(band_code)); // R7
endmodule

// File: tb/band_select_sequencer_test.sv
module band_select_sequencer_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pfd_tick = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       nlatch_wr = 1'b0;
    logic       tune_isolate;
    logic       sel_done;
    logic [2:0] band_code;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Behavioural model state
    int m_pc = 0, m_wc = 0, m_run = 1, m_done = 0, m_band = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    band_select_sequencer uut (
        .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .div_sel(div_sel),
        .nlatch_wr(nlatch_wr), .tune_isolate(tune_isolate),
        .sel_done(sel_done), .band_code(band_code)
    );

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Advance the model by one rising edge using the inputs that were driven.
    task automatic model_edge(bit r, bit trig, bit pd, int sel);
        int d;
        bit bs;
        if (!r || trig) begin
            m_pc = 0; m_wc = 0; m_run = 1; m_done = 0;
            if (!r) m_band = 0;
        end else begin
            m_done = 0;
            if (pd) begin
                d = 1 << sel;
                bs = ((m_pc % d) == d - 1);
                m_pc = (m_pc + 1) % 8;
                if (bs && m_run == 1) begin
                    if (m_wc == 4) begin
                        m_run = 0; m_done = 1; m_wc = 0;
                        m_band = (m_band + 1) % 8;
                    end else begin
                        m_wc++;
                    end
                end
            end
        end
    endtask

    task automatic cycle(bit trig, bit pd);
        @(negedge clk);
        nlatch_wr = trig;
        pfd_tick = pd;
        @(posedge clk);
        model_edge(rst_n, trig, pd, int'(div_sel));
        #(CLK_PERIOD/4);
        check("R4", int'(tune_isolate), m_run, "isolate");
        check("R5", int'(sel_done), m_done, "done");
        check("R7", int'(band_code), m_band, "band");
    endtask

    // Tick every cycle until completion; return the number of cycles taken.
    task automatic measure(output int n);
        n = 0;
        for (int k = 0; k < 200; k++) begin
            cycle(1'b0, 1'b1);
            n++;
            if (sel_done) break;
        end
    endtask

    initial begin
        int n;
        int b0;
        int unsigned seed_v;
        seed_v = $urandom(32'h5EED);

        // R1: reset state
        rst_n = 1'b0;
        cycle(1'b0, 1'b0);
        check("R1", int'(tune_isolate), 1, "reset isolate");
        check("R1", int'(sel_done), 0, "reset done");
        check("R1", int'(band_code), 0, "reset band");
        cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: power-up window runs after reset release
        div_sel = 2'd0;
        measure(n);
        check("R1", n, 5, "power-up window cycles");

        // R2/R3: window length for each prescale
        for (int s = 0; s < 4; s++) begin
            div_sel = 2'(s);
            cycle(1'b1, 1'b0);
            measure(n);
            check((s == 0) ? "R3" : "R2", n, 5 << s, "window cycles");
        end

        // R6/R7: restart mid-window, trigger coinciding with a tick
        div_sel = 2'd0;
        b0 = int'(band_code);
        cycle(1'b1, 1'b0);
        cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        measure(n);
        check("R6", n, 5, "restarted window cycles");
        check("R7", int'(band_code), (b0 + 1) % 8, "band after restart");

        // R8: idle ticks have no effect
        b0 = int'(band_code);
        for (int k = 0; k < 20; k++) cycle(1'b0, 1'b1);
        check("R8", int'(tune_isolate), 0, "idle isolate");
        check("R8", int'(band_code), b0, "idle band");

        // R2/R6: sparse ticks, divide by 2 (model-checked every cycle)
        div_sel = 2'd1;
        cycle(1'b1, 1'b0);
        for (int k = 0; k < 40; k++) cycle(1'b0, (k % 3) == 0);

        // Random traffic with occasional prescale changes and triggers
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) div_sel = 2'($urandom % 4);
            cycle(($urandom % 40) == 0, ($urandom % 2) == 1);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule